// File: doc/BRIEF.md
# Boundary-Scan Chain Continuity Tester

This block drives a boundary-scan chain on its own and reports whether the chain is intact. It produces the test clock, the mode-select line and the serial data line toward a chain of target devices, and it reads the serial data that comes back. Each trial takes every test access port to its reset state and then to the idle state. It then runs one instruction-register capture and shift pass while the outgoing data line stays high. Every bit that returns is compared with the capture signature: each device returns a single one followed by zeros, and the device closest to the return pin is heard first.

A run starts on a one-cycle `start` pulse and performs `loopCount` trials back to back. One miscompared bit marks its trial as failed. The run keeps saturating pass and fail tallies, a sticky flag with the position of the first wrong bit, and a final verdict. The device count, the instruction-register length, the clock divider and the counter widths are parameters. The test clock runs at the system clock divided by `2*HALF_DIV`.

Top module: `jtag_chain_checker`

## Requirements
- R1: While `rstN` is low and after it is released, `busy`, `done`, `tck`, `chainOk`, `failSeen`, `passCount`, `failCount` and `firstFailIdx` are all 0.
- R2: `tck` is low whenever `busy` is low. During a run each `tck` high phase and each low phase lasts `HALF_DIV` system clocks. A run of T trials keeps `busy` high for exactly T*(12+DEV_COUNT*IR_LEN)*2*HALF_DIV cycles. `tms` and `tdi` change only together with a falling `tck` edge or at the start of a run.
- R3: Each trial opens with five `tck` pulses with `tms`=1 and then one pulse with `tms`=0, which takes every device to the idle state.
- R4: The six opening pulses are followed by two pulses with `tms`=1, two with `tms`=0, then DEV_COUNT*IR_LEN-1 pulses with `tms`=0, then two with `tms`=1 and a final pulse with `tms`=0. A trial therefore has exactly 12+DEV_COUNT*IR_LEN pulses, and no pulse is produced outside a trial.
- R5: `tdi` is 1 at every rising `tck` edge of a trial.
- R6: `tdo` is sampled at the rising edges of pulses 11 through 10+DEV_COUNT*IR_LEN of each trial, counted from 1, which gives DEV_COUNT*IR_LEN bits numbered from 0. Bit k is expected to be 1 when k is a multiple of IR_LEN and 0 otherwise.
- R7: At the end of a trial, `failCount` rises by one if any sampled bit differed from its expected value, and `passCount` rises by one otherwise. Both counters stop at 2^CNT_W-1.
- R8: `failSeen` goes to 1 at the first miscompare after a start and stays there. `firstFailIdx` holds the bit number of that first miscompare and does not change afterwards.
- R9: A run performs `loopCount` trials without gaps. `done` is a one-cycle pulse in the cycle after the last falling `tck` edge, in the same cycle that `busy` falls. `chainOk` is 1 after a run only when at least one trial ran and none failed.
- R10: A `start` sampled while `busy` is low clears the counters, `failSeen`, `firstFailIdx` and `chainOk`. A `start` sampled while `busy` is high has no effect.
- R11: A start with `loopCount`=0 produces no `tck` pulse, raises `done` in the next cycle, never raises `busy`, and leaves `chainOk` at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins a run when the block is idle |
| loopCount | input | LOOP_W | Number of trials in the run |
| tdo | input | 1 | Serial data returned by the chain |
| tck | output | 1 | Test clock toward the chain |
| tms | output | 1 | Mode select toward the chain |
| tdi | output | 1 | Serial data toward the chain |
| busy | output | 1 | High while a run is in progress |
| done | output | 1 | One-cycle pulse at the end of a run |
| chainOk | output | 1 | Verdict of the last run |
| passCount | output | CNT_W | Saturating count of good trials |
| failCount | output | CNT_W | Saturating count of failed trials |
| failSeen | output | 1 | Sticky flag for a miscompare |
| firstFailIdx | output | IDX_W | Bit number of the first miscompare |

## Verification
A wrong pulse counter or a bad mode-select decode changes the level of `tms` at one specific rising edge. A scoreboard that checks every pulse against the scripted sequence catches this within one test-clock period, and a reference chain model would capture the wrong bits. A slip in the comparator's bit or device position shows up only at `done`: the pass and fail tallies and `firstFailIdx` come out wrong. Faults are therefore injected at chosen bit positions of chosen trials, so a position error gives a count or index that differs from the expected one. A divider error shows up as a wrong high-phase width on `tck` and as a wrong run length in cycles.

// File: rtl/jtag_chk_pkg.sv
`timescale 1ns/1ps
package jtag_chk_pkg;

  // Strobes from the sequencer to the compare datapath
  typedef struct packed {
    logic clear;     // run accepted: wipe results
    logic sample;    // rising tck inside the capture window
    logic trialEnd;  // falling tck of the last pulse of a trial
    logic runEnd;    // last trial of the run is ending
  } chkStrobe_t;

  // Fixed pulse counts of the scripted sequence
  localparam int RESET_PULSES = 5;
  localparam int IDLE_PULSES  = 1;
  localparam int SCAN_LEAD    = 4;  // two high, two low before shifting
  localparam int SCAN_TAIL    = 3;  // exit, update, back to idle
  localparam int OVERHEAD     = RESET_PULSES + IDLE_PULSES + SCAN_LEAD + SCAN_TAIL - 1;

endpackage

// File: rtl/jtag_chk_tckgen.sv
`timescale 1ns/1ps
module jtag_chk_tckgen #(
  parameter int HALF_DIV = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic run,
  output logic halfDone
);
  localparam int DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic [DIV_W-1:0] divCnt;

  assign halfDone = run && (divCnt == DIV_W'(HALF_DIV - 1));

  always_ff @(posedge clk) begin
    if (!rstN || !run) begin
      divCnt <= '0;
    end else if (halfDone) begin
      divCnt <= '0;
    end else begin
      divCnt <= divCnt + 1'b1;
    end
  end
endmodule

// File: rtl/jtag_chk_ctrl.sv
`timescale 1ns/1ps
module jtag_chk_ctrl
  import jtag_chk_pkg::*;
#(
  parameter int DEV_COUNT = 2,
  parameter int IR_LEN    = 8,
  parameter int LOOP_W    = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [LOOP_W-1:0] loopCount,
  input  logic              halfDone,
  output logic              tck,
  output logic              tms,
  output logic              tdi,
  output logic              busy,
  output logic              done,
  output chkStrobe_t        strobe
);
  localparam int BITS    = DEV_COUNT * IR_LEN;
  localparam int PULSES  = OVERHEAD + BITS;
  localparam int PW      = $clog2(PULSES);
  localparam logic [PW-1:0] LAST_IDX  = PW'(PULSES - 1);
  localparam logic [PW-1:0] WIN_FIRST = PW'(RESET_PULSES + IDLE_PULSES + SCAN_LEAD);
  localparam logic [PW-1:0] WIN_LAST  = PW'(RESET_PULSES + IDLE_PULSES + SCAN_LEAD + BITS - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_LOW, ST_HIGH} ctrlState_t;

  ctrlState_t        state;
  logic [PW-1:0]     pulseIdx;
  logic [LOOP_W-1:0] trialsLeft;
  logic              tckR, tmsR, tdiR, doneR;
  logic              startOk, lastPulse, inWindow;

  // Mode-select level for a given pulse of the trial script
  function automatic logic tmsFor(input logic [PW-1:0] idx);
    logic lvl;
    if (idx < PW'(RESET_PULSES))                          lvl = 1'b1;
    else if (idx < PW'(RESET_PULSES + IDLE_PULSES))       lvl = 1'b0;
    else if (idx < PW'(RESET_PULSES + IDLE_PULSES + 2))   lvl = 1'b1;
    else if (idx > WIN_LAST - PW'(1) && idx < LAST_IDX)   lvl = 1'b1;
    else                                                  lvl = 1'b0;
    return lvl;
  endfunction

  assign startOk   = start && (state == ST_IDLE);
  assign lastPulse = (pulseIdx == LAST_IDX);
  assign inWindow  = (pulseIdx >= WIN_FIRST) && (pulseIdx <= WIN_LAST);

  always_comb begin
    strobe          = '0;
    strobe.clear    = startOk;
    strobe.sample   = (state == ST_LOW) && halfDone && inWindow;
    strobe.trialEnd = (state == ST_HIGH) && halfDone && lastPulse;
    strobe.runEnd   = strobe.trialEnd && (trialsLeft == LOOP_W'(1));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      pulseIdx   <= '0;
      trialsLeft <= '0;
      tckR       <= 1'b0;
      tmsR       <= 1'b0;
      tdiR       <= 1'b0;
      doneR      <= 1'b0;
    end else begin
      doneR <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (startOk) begin
            if (loopCount == '0) begin
              doneR <= 1'b1;
            end else begin
              state      <= ST_LOW;
              pulseIdx   <= '0;
              trialsLeft <= loopCount;
              tmsR       <= tmsFor('0);
              tdiR       <= 1'b1;
            end
          end
        end
        ST_LOW: begin
          if (halfDone) begin
            tckR  <= 1'b1;
            state <= ST_HIGH;
          end
        end
        ST_HIGH: begin
          if (halfDone) begin
            tckR <= 1'b0;
            if (lastPulse) begin
              pulseIdx <= '0;
              if (trialsLeft == LOOP_W'(1)) begin
                state <= ST_IDLE;
                doneR <= 1'b1;
                tdiR  <= 1'b0;
                tmsR  <= 1'b0;
              end else begin
                trialsLeft <= trialsLeft - 1'b1;
                tmsR       <= tmsFor('0);
                state      <= ST_LOW;
              end
            end else begin
              pulseIdx <= pulseIdx + 1'b1;
              tmsR     <= tmsFor(PW'(pulseIdx + 1'b1));
              state    <= ST_LOW;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign tck  = tckR;
  assign tms  = tmsR;
  assign tdi  = tdiR;
  assign busy = (state != ST_IDLE);
  assign done = doneR;
endmodule

// File: rtl/jtag_chk_dpath.sv
`timescale 1ns/1ps
module jtag_chk_dpath
  import jtag_chk_pkg::*;
#(
  parameter int DEV_COUNT = 2,
  parameter int IR_LEN    = 8,
  parameter int CNT_W     = 16,
  parameter int IDX_W     = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tdo,
  input  chkStrobe_t       strobe,
  output logic [CNT_W-1:0] passCount,
  output logic [CNT_W-1:0] failCount,
  output logic             failSeen,
  output logic [IDX_W-1:0] firstFailIdx,
  output logic             chainOk
);
  localparam int DB_W = (IR_LEN > 1) ? $clog2(IR_LEN) : 1;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [IDX_W-1:0] bitIdx;
  logic [DB_W-1:0]  devBit;
  logic             trialBad;
  logic             expBit, miss;

  // First bit of every device's slice is the capture marker
  assign expBit = (devBit == '0);
  assign miss   = strobe.sample && (tdo != expBit);

  always_ff @(posedge clk) begin
    if (!rstN || strobe.clear) begin
      bitIdx       <= '0;
      devBit       <= '0;
      trialBad     <= 1'b0;
      passCount    <= '0;
      failCount    <= '0;
      failSeen     <= 1'b0;
      firstFailIdx <= '0;
      chainOk      <= 1'b0;
    end else begin
      if (strobe.sample) begin
        bitIdx <= bitIdx + 1'b1;
        devBit <= (devBit == DB_W'(IR_LEN - 1)) ? '0 : devBit + 1'b1;
        if (miss) begin
          trialBad <= 1'b1;
          if (!failSeen) begin
            failSeen     <= 1'b1;
            firstFailIdx <= bitIdx;
          end
        end
      end
      if (strobe.trialEnd) begin
        bitIdx   <= '0;
        devBit   <= '0;
        trialBad <= 1'b0;
        if (trialBad) begin
          if (failCount != CNT_MAX) failCount <= failCount + 1'b1;
        end else begin
          if (passCount != CNT_MAX) passCount <= passCount + 1'b1;
        end
      end
      if (strobe.runEnd) begin
        chainOk <= !failSeen;
      end
    end
  end
endmodule

// File: rtl/jtag_chain_checker.sv
`timescale 1ns/1ps
module jtag_chain_checker
  import jtag_chk_pkg::*;
#(
  parameter int HALF_DIV  = 4,
  parameter int DEV_COUNT = 2,
  parameter int IR_LEN    = 8,
  parameter int LOOP_W    = 16,
  parameter int CNT_W     = 16,
  localparam int BITS     = DEV_COUNT * IR_LEN,
  localparam int IDX_W    = (BITS > 1) ? $clog2(BITS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [LOOP_W-1:0] loopCount,
  input  logic              tdo,
  output logic              tck,
  output logic              tms,
  output logic              tdi,
  output logic              busy,
  output logic              done,
  output logic              chainOk,
  output logic [CNT_W-1:0]  passCount,
  output logic [CNT_W-1:0]  failCount,
  output logic              failSeen,
  output logic [IDX_W-1:0]  firstFailIdx
);
  chkStrobe_t strobe;
  logic       halfDone;

  jtag_chk_tckgen #(.HALF_DIV(HALF_DIV)) u_tckgen (
    .clk      (clk),
    .rstN     (rstN),
    .run      (busy),
    .halfDone (halfDone)
  );

  jtag_chk_ctrl #(
    .DEV_COUNT (DEV_COUNT),
    .IR_LEN    (IR_LEN),
    .LOOP_W    (LOOP_W)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .loopCount (loopCount),
    .halfDone  (halfDone),
    .tck       (tck),
    .tms       (tms),
    .tdi       (tdi),
    .busy      (busy),
    .done      (done),
    .strobe    (strobe)
  );

  jtag_chk_dpath #(
    .DEV_COUNT (DEV_COUNT),
    .IR_LEN    (IR_LEN),
    .CNT_W     (CNT_W),
    .IDX_W     (IDX_W)
  ) u_dpath (
    .clk          (clk),
    .rstN         (rstN),
    .tdo          (tdo),
    .strobe       (strobe),
    .passCount    (passCount),
    .failCount    (failCount),
    .failSeen     (failSeen),
    .firstFailIdx (firstFailIdx),
    .chainOk      (chainOk)
  );
endmodule

// File: rtl/jtag_chk_sva.sv
`timescale 1ns/1ps
module jtag_chk_sva #(
  parameter int CNT_W = 16,
  parameter int IDX_W = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             tck,
  input logic             tms,
  input logic             tdi,
  input logic             busy,
  input logic             done,
  input logic             chainOk,
  input logic [CNT_W-1:0] passCount,
  input logic [CNT_W-1:0] failCount,
  input logic             failSeen,
  input logic [IDX_W-1:0] firstFailIdx
);
  AST_TCK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !tck); // R2
  AST_PINS_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (tck && $past(tck)) |-> ($stable(tms) && $stable(tdi))); // R2
  AST_TDI_HIGH_RUN: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> tdi); // R5
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R9
  AST_BUSY_FALL_DONE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done); // R9
  AST_PASS_MONOTONIC: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> (passCount >= $past(passCount))); // R7
  AST_FAIL_MONOTONIC: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> (failCount >= $past(failCount))); // R7
  AST_FIRST_FAIL_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (failSeen && $past(failSeen)) |-> $stable(firstFailIdx)); // R8
  AST_OK_NO_FAIL: assert property (@(posedge clk) disable iff (!rstN)
    chainOk |-> (!failSeen && failCount == '0)); // R9
endmodule

bind jtag_chain_checker jtag_chk_sva #(.CNT_W(CNT_W), .IDX_W(IDX_W)) u_sva (
  .clk          (clk),
  .rstN         (rstN),
  .tck          (tck),
  .tms          (tms),
  .tdi          (tdi),
  .busy         (busy),
  .done         (done),
  .chainOk      (chainOk),
  .passCount    (passCount),
  .failCount    (failCount),
  .failSeen     (failSeen),
  .firstFailIdx (firstFailIdx)
);

// File: tb/jtag_chain_checker_tb.sv
`timescale 1ns/1ps
module jtag_chain_checker_tb;
  localparam int HALF_DIV  = 2;
  localparam int DEV_COUNT = 2;
  localparam int IR_LEN    = 8;
  localparam int LOOP_W    = 8;
  localparam int CNT_W     = 3;
  localparam int BITS      = DEV_COUNT * IR_LEN;
  localparam int IDX_W     = $clog2(BITS);
  localparam int PULSES    = 12 + BITS;
  localparam int SAT       = (1 << CNT_W) - 1;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic              rstN = 1'b0;
  logic              start = 1'b0;
  logic [LOOP_W-1:0] loopCount = '0;
  logic              tdo;
  logic              tck, tms, tdi, busy, done, chainOk, failSeen;
  logic [CNT_W-1:0]  passCount, failCount;
  logic [IDX_W-1:0]  firstFailIdx;

  int checks = 0;
  int fails  = 0;

  jtag_chain_checker #(
    .HALF_DIV(HALF_DIV), .DEV_COUNT(DEV_COUNT), .IR_LEN(IR_LEN),
    .LOOP_W(LOOP_W), .CNT_W(CNT_W)
  ) u_dut (
    .clk(clk), .rstN(rstN), .start(start), .loopCount(loopCount), .tdo(tdo),
    .tck(tck), .tms(tms), .tdi(tdi), .busy(busy), .done(done),
    .chainOk(chainOk), .passCount(passCount), .failCount(failCount),
    .failSeen(failSeen), .firstFailIdx(firstFailIdx)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // ---------------- reference chain of TAP devices ----------------
  typedef enum logic [3:0] {TLR, RTI, SDR, CDR, SHDR, E1DR, PDR, E2DR, UDR,
                            SIR, CIR, SHIR, E1IR, PIR, E2IR, UIR} tapSt_t;

  function automatic tapSt_t tapNext(input tapSt_t s, input logic m);
    case (s)
      TLR:  return m ? TLR  : RTI;
      RTI:  return m ? SDR  : RTI;
      SDR:  return m ? SIR  : CDR;
      CDR:  return m ? E1DR : SHDR;
      SHDR: return m ? E1DR : SHDR;
      E1DR: return m ? UDR  : PDR;
      PDR:  return m ? E2DR : PDR;
      E2DR: return m ? UDR  : SHDR;
      UDR:  return m ? SDR  : RTI;
      SIR:  return m ? TLR  : CIR;
      CIR:  return m ? E1IR : SHIR;
      SHIR: return m ? E1IR : SHIR;
      E1IR: return m ? UIR  : PIR;
      PIR:  return m ? E2IR : PIR;
      E2IR: return m ? UIR  : SHIR;
      default: return m ? SDR : RTI;
    endcase
  endfunction

  tapSt_t            tapSt = TLR;
  logic [IR_LEN-1:0] irReg [DEV_COUNT];
  logic              devTdo [DEV_COUNT];
  logic              flipNow = 1'b0;
  int                outIdx = 0;
  int                trialCnt = 0;
  bit                stuckLow = 1'b0;
  bit                faultOn = 1'b0;
  int                faultTrial = 0;
  int                faultBit = 0;

  always @(posedge tck) begin
    for (int d = 0; d < DEV_COUNT; d++) begin
      if (tapSt == CIR) begin
        irReg[d] <= IR_LEN'(1);
      end else if (tapSt == SHIR) begin
        if (d == 0) irReg[d] <= {tdi, irReg[d][IR_LEN-1:1]};
        else        irReg[d] <= {devTdo[d-1], irReg[d][IR_LEN-1:1]};
      end
    end
    if (tapSt == CIR) trialCnt <= trialCnt + 1;
    tapSt <= tapNext(tapSt, tms);
  end

  always @(negedge tck) begin
    for (int d = 0; d < DEV_COUNT; d++) begin
      devTdo[d] <= (tapSt == SHIR) ? irReg[d][0] : 1'b0;
    end
    if (tapSt == SHIR) begin
      flipNow <= faultOn && (trialCnt == faultTrial) && (outIdx == faultBit);
      outIdx  <= outIdx + 1;
    end else begin
      flipNow <= 1'b0;
      outIdx  <= 0;
    end
  end

  assign tdo = stuckLow ? 1'b0 : (devTdo[DEV_COUNT-1] ^ flipNow);

  // ---------------- scoreboard of scripted pin levels ----------------
  typedef struct { logic tmsExp; int idx; } expItem_t;
  expItem_t expQ[$];

  function automatic logic refTms(input int p);
    if (p < 5) return 1'b1;           // reset pulses
    if (p == 5) return 1'b0;          // into idle
    if (p < 8) return 1'b1;           // select DR, select IR
    if (p == BITS + 9 || p == BITS + 10) return 1'b1;  // exit, update
    return 1'b0;
  endfunction

  task automatic pushTrials(input int n);
    for (int t = 0; t < n; t++) begin
      for (int p = 0; p < PULSES; p++) begin
        expItem_t it;
        it.tmsExp = refTms(p);
        it.idx    = p;
        expQ.push_back(it);
      end
    end
  endtask

  time riseT = 0;
  always @(posedge tck) begin
    expItem_t it;
    riseT = $time;
    if (expQ.size() == 0) begin
      chk(1'b0, "R4", "tck pulse outside a trial", 1, 0);
    end else begin
      it = expQ.pop_front();
      chk(tms == it.tmsExp, (it.idx < 6) ? "R3" : "R4", "tms level at pulse",
          int'(tms), int'(it.tmsExp));
      chk(tdi == 1'b1, "R5", "tdi level during trial", int'(tdi), 1);
    end
  end

  always @(negedge tck) begin
    chk(($time - riseT) == HALF_DIV * 8, "R2", "tck high time ns",
        int'($time - riseT), HALF_DIV * 8);
  end

  // ---------------- driver ----------------
  task automatic runTest(input int loops, input bit restartMid, output int busyCyc);
    @(negedge clk);
    loopCount = LOOP_W'(loops);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    busyCyc = 0;
    forever begin
      if (done) break;
      if (busy) busyCyc++;
      start = restartMid && (busyCyc == 20);
      @(negedge clk);
    end
    start = 1'b0;
    chk(expQ.size() == 0, "R4", "pulses missing at run end", expQ.size(), 0);
  endtask

  task automatic checkResult(input string req, input int p, input int f,
                             input bit seen, input int idx, input bit ok);
    chk(int'(passCount) == p, req, "passCount", int'(passCount), p);
    chk(int'(failCount) == f, req, "failCount", int'(failCount), f);
    chk(failSeen == seen, req, "failSeen", int'(failSeen), int'(seen));
    if (seen) chk(int'(firstFailIdx) == idx, req, "firstFailIdx", int'(firstFailIdx), idx);
    chk(chainOk == ok, req, "chainOk", int'(chainOk), int'(ok));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R9 watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int cyc;
    repeat (4) @(negedge clk);
    chk(busy == 0 && done == 0 && tck == 0, "R1", "control outputs in reset",
        int'({busy, done, tck}), 0);
    rstN = 1'b1;
    @(negedge clk);
    checkResult("R1", 0, 0, 1'b0, 0, 1'b0);

    // Healthy chain, three trials
    pushTrials(3);
    runTest(3, 1'b0, cyc);
    chk(cyc == 3 * PULSES * 2 * HALF_DIV, "R2", "busy cycles for 3 trials", cyc, 3 * PULSES * 2 * HALF_DIV);
    checkResult("R9", 3, 0, 1'b0, 0, 1'b1);
    chk(tck == 0 && busy == 0, "R2", "tck idle low after run", int'(tck), 0);

    // Broken chain: return line stuck low, the first marker is lost
    stuckLow = 1'b1;
    pushTrials(2);
    runTest(2, 1'b0, cyc);
    checkResult("R6", 0, 2, 1'b1, 0, 1'b0);
    stuckLow = 1'b0;

    // One flipped zero at bit 9 in the second of four trials
    faultOn = 1'b1; faultTrial = trialCnt + 2; faultBit = 9;
    pushTrials(4);
    runTest(4, 1'b0, cyc);
    checkResult("R8", 3, 1, 1'b1, 9, 1'b0);

    // Marker of the far device (bit 8) lost in the first of two trials
    faultTrial = trialCnt + 1; faultBit = 8;
    pushTrials(2);
    runTest(2, 1'b0, cyc);
    checkResult("R6", 1, 1, 1'b1, 8, 1'b0);
    faultOn = 1'b0;

    // New start clears old results
    pushTrials(2);
    runTest(2, 1'b0, cyc);
    checkResult("R10", 2, 0, 1'b0, 0, 1'b1);

    // Start during a run has no effect
    pushTrials(2);
    runTest(2, 1'b1, cyc);
    chk(cyc == 2 * PULSES * 2 * HALF_DIV, "R10", "busy cycles with restart", cyc, 2 * PULSES * 2 * HALF_DIV);
    checkResult("R10", 2, 0, 1'b0, 0, 1'b1);

    // Zero trials
    runTest(0, 1'b0, cyc);
    chk(cyc == 0, "R11", "busy cycles for zero loops", cyc, 0);
    checkResult("R11", 0, 0, 1'b0, 0, 1'b0);

    // Pass counter saturation
    pushTrials(SAT + 2);
    runTest(SAT + 2, 1'b0, cyc);
    checkResult("R7", SAT, 0, 1'b0, 0, 1'b1);

    // Fail counter saturation
    stuckLow = 1'b1;
    pushTrials(SAT + 2);
    runTest(SAT + 2, 1'b0, cyc);
    checkResult("R7", 0, SAT, 1'b1, 0, 1'b0);
    stuckLow = 1'b0;

    repeat (4) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule